// File: doc/BRIEF.md
# BCD Calendar Counter With Hold

This block keeps wall-clock time and date as seven packed-BCD fields: seconds, minutes, hours (24-hour, 00 to 23), weekday (0 to 6), day of month, month and a two-digit year that spans 2000 to 2099. A one-cycle `tick_1hz` pulse advances the seconds. Carries ripple through the fields in the same clock edge. The length of each month and the leap-year rule for February are derived from the stored month and year.

Software changes the time through a freeze handshake. It raises `hold_req`, which stops counting at once. It then waits for `hold_ack`, which rises only after two pulses of the slow `slow_en` strobe, standing in for two 32 kHz periods. While `hold_ack` is high, the field-select write port loads any field. Dropping `hold_req` resumes counting.

All reads come from a shadow bank, not from the live counters. The shadow bank copies the live fields one cycle after they change and updates every field in the same cycle. A reader that samples the seconds copy before and after a multi-field read can therefore detect a seconds change that happened during the read.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the read copies show 00:00:00, weekday 0, day 01, month 01, year 00, and `hold_ack` is low.
- R2: When `run_en` is high and `hold_req` is low, a `tick_1hz` pulse increments the seconds in BCD (09 becomes 10, 59 becomes 00).
- R3: While `run_en` is low, `tick_1hz` pulses change no field.
- R4: A seconds wrap increments the minutes. A minutes wrap increments the hours. The hours wrap from 23 to 00 and increment both the day of month and the weekday.
- R5: The weekday wraps from 6 to 0.
- R6: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00.
- R7: In month 02 the last day is 29 when the BCD year is a multiple of 4 (00 counts as one), and 28 otherwise.
- R8: While `hold_req` is high, ticks are ignored. `hold_ack` rises in the cycle after the second `slow_en` pulse seen with `hold_req` high. It falls one cycle after `hold_req` goes low.
- R9: A write with `wr_en` high loads `wr_data` into the field chosen by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year). The write takes effect only while both `hold_req` and `hold_ack` are high. At all other times it is ignored.
- R10: The read copies show the live fields with a one-cycle lag, and all seven copies update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| slow_en | input | 1 | One-cycle strobe per slow (32 kHz) period |
| run_en | input | 1 | Counting enable |
| hold_req | input | 1 | Freeze request |
| hold_ack | output | 1 | Freeze confirmed; writes accepted |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 8 | BCD value to load |
| rd_sec | output | 8 | Seconds copy, BCD |
| rd_min | output | 8 | Minutes copy, BCD |
| rd_hour | output | 8 | Hours copy, BCD |
| rd_wday | output | 8 | Weekday copy, 0 to 6 |
| rd_day | output | 8 | Day of month copy, BCD |
| rd_mon | output | 8 | Month copy, BCD |
| rd_year | output | 8 | Two-digit year copy, BCD |

## Verification
The live fields reach the ports only through the shadow bank. A wrong carry, month length or leap decision therefore appears on the read copies exactly two edges after the tick that caused it, and then persists. A wrong handshake count shows on `hold_ack` in the cycle after the second strobe. It also shows on the first write after that strobe, which is either lost or wrongly accepted. The bench loads dates just before each boundary, so every rollover is exposed within one tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW = 8;
  localparam int FIELDS = 7;

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
    F_DAY = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
  } field_e;

  // lowest legal value of each field (day and month start at 1)
  function automatic logic [FW-1:0] field_floor(int idx);
    return (idx == int'(F_DAY) || idx == int'(F_MON)) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [FW-1:0] bcd_inc(logic [FW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year value is a multiple of 4: even tens need ones 0/4/8, odd tens 2/6
  function automatic logic leap_year(logic [FW-1:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [FW-1:0] last_day(logic [FW-1:0] mon, logic [FW-1:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_field.sv
module cal_field
  import cal_pkg::*;
#(
  parameter logic [FW-1:0] FLOOR = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic [FW-1:0] ceil_val,
  input  logic          ld,
  input  logic [FW-1:0] ld_val,
  output logic [FW-1:0] val,
  output logic          at_ceil
);
  assign at_ceil = (val >= ceil_val);

  always_ff @(posedge clk) begin
    if (rst)      val <= FLOOR;
    else if (ld)  val <= ld_val;
    else if (inc) val <= at_ceil ? FLOOR : bcd_inc(val);
  end
endmodule

// File: rtl/cal_hold.sv
module cal_hold #(
  parameter int ACK_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic slow_en,
  output logic hold_ack
);
  localparam int CW = $clog2(ACK_PULSES + 1);
  localparam logic [CW-1:0] DONE = CW'(ACK_PULSES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !hold_req)            cnt <= '0;
    else if (slow_en && cnt != DONE) cnt <= cnt + CW'(1);
  end

  assign hold_ack = (cnt == DONE);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int ACK_PULSES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_1hz,
  input  logic          slow_en,
  input  logic          run_en,
  input  logic          hold_req,
  output logic          hold_ack,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [FW-1:0] wr_data,
  output logic [FW-1:0] rd_sec,
  output logic [FW-1:0] rd_min,
  output logic [FW-1:0] rd_hour,
  output logic [FW-1:0] rd_wday,
  output logic [FW-1:0] rd_day,
  output logic [FW-1:0] rd_mon,
  output logic [FW-1:0] rd_year
);
  logic [FW-1:0]     live   [FIELDS];
  logic [FW-1:0]     ceil_v [FIELDS];
  logic [FW-1:0]     shadow [FIELDS];
  logic [FIELDS-1:0] inc, at_ceil, ld;
  logic              step, wr_ok;

  cal_hold #(.ACK_PULSES(ACK_PULSES)) u_hold (
    .clk(clk), .rst(rst), .hold_req(hold_req), .slow_en(slow_en), .hold_ack(hold_ack)
  );

  assign step  = tick_1hz & run_en & ~hold_req;
  assign wr_ok = wr_en & hold_req & hold_ack;

  // carry chain: weekday and day both advance on the hour wrap
  always_comb begin
    inc[F_SEC]  = step;
    inc[F_MIN]  = inc[F_SEC]  & at_ceil[F_SEC];
    inc[F_HOUR] = inc[F_MIN]  & at_ceil[F_MIN];
    inc[F_WDAY] = inc[F_HOUR] & at_ceil[F_HOUR];
    inc[F_DAY]  = inc[F_HOUR] & at_ceil[F_HOUR];
    inc[F_MON]  = inc[F_DAY]  & at_ceil[F_DAY];
    inc[F_YEAR] = inc[F_MON]  & at_ceil[F_MON];
    ceil_v[F_SEC]  = 8'h59;
    ceil_v[F_MIN]  = 8'h59;
    ceil_v[F_HOUR] = 8'h23;
    ceil_v[F_WDAY] = 8'h06;
    ceil_v[F_DAY]  = last_day(live[F_MON], live[F_YEAR]);
    ceil_v[F_MON]  = 8'h12;
    ceil_v[F_YEAR] = 8'h99;
  end

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    assign ld[i] = wr_ok && (wr_sel == 3'(i));

    cal_field #(.FLOOR(field_floor(i))) u_field (
      .clk(clk), .rst(rst), .inc(inc[i]), .ceil_val(ceil_v[i]),
      .ld(ld[i]), .ld_val(wr_data), .val(live[i]), .at_ceil(at_ceil[i])
    );

    always_ff @(posedge clk) begin
      if (rst) shadow[i] <= field_floor(i);
      else     shadow[i] <= live[i];
    end
  end

  assign rd_sec  = shadow[F_SEC];
  assign rd_min  = shadow[F_MIN];
  assign rd_hour = shadow[F_HOUR];
  assign rd_wday = shadow[F_WDAY];
  assign rd_day  = shadow[F_DAY];
  assign rd_mon  = shadow[F_MON];
  assign rd_year = shadow[F_YEAR];
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       slow_en,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       wr_en,
  input logic [7:0] rd_sec,
  input logic [7:0] rd_wday
);
  // R8
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> $past(hold_req));
  // R8
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(slow_en));
  // R8
  frozen_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_req && !wr_en) |=> ##1 $stable(rd_sec));
  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_1hz && !wr_en) |=> ##1 $stable(rd_sec));
  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sec <= 8'h59) && (rd_sec[3:0] <= 4'd9));
  // R5
  wday_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_wday <= 8'h06);
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .slow_en(slow_en),
  .hold_req(hold_req), .hold_ack(hold_ack), .wr_en(wr_en),
  .rd_sec(rd_sec), .rd_wday(rd_wday)
);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  logic clk = 1'b0, rst = 1'b1;
  logic tick_1hz = 0, slow_en = 0, run_en = 0, hold_req = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic hold_ack;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_wday, rd_day, rd_mon, rd_year;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_calendar u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .slow_en(slow_en), .run_en(run_en),
    .hold_req(hold_req), .hold_ack(hold_ack), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour),
    .rd_wday(rd_wday), .rd_day(rd_day), .rd_mon(rd_mon), .rd_year(rd_year)
  );

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int frombcd(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic int month_len(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // reference model: binary fields, index 0 sec .. 6 year
  int m [7];
  int shd [7];
  int hcnt;

  task automatic model_reset();
    for (int i = 0; i < 7; i++) begin
      m[i] = (i == 4 || i == 5) ? 1 : 0;
      shd[i] = m[i];
    end
    hcnt = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      for (int i = 0; i < 7; i++) shd[i] = m[i];
      if (wr_en && hold_req && hcnt == 2 && wr_sel < 3'd7)
        m[wr_sel] = frombcd(wr_data);
      else if (tick_1hz && run_en && !hold_req) begin
        m[0]++;
        if (m[0] == 60) begin
          m[0] = 0; m[1]++;
          if (m[1] == 60) begin
            m[1] = 0; m[2]++;
            if (m[2] == 24) begin
              m[2] = 0; m[3] = (m[3] + 1) % 7; m[4]++;
              if (m[4] > month_len(m[5], m[6])) begin
                m[4] = 1; m[5]++;
                if (m[5] == 13) begin m[5] = 1; m[6] = (m[6] + 1) % 100; end
              end
            end
          end
        end
      end
      if (!hold_req) hcnt = 0;
      else if (slow_en && hcnt < 2) hcnt++;
    end
  end

  // R10: every-cycle comparison of all read copies and the acknowledge
  always @(negedge clk) begin
    if (!rst) begin
      logic [7:0] act [7];
      act = '{rd_sec, rd_min, rd_hour, rd_wday, rd_day, rd_mon, rd_year};
      for (int i = 0; i < 7; i++) begin
        checks++;
        if (act[i] !== tobcd(shd[i])) begin
          errors++;
          $display("FAIL R10 model field %0d actual %h expected %h", i, act[i], tobcd(shd[i]));
        end
      end
      checks++;
      if (hold_ack !== (hcnt == 2)) begin
        errors++;
        $display("FAIL R8 model hold_ack actual %b expected %b", hold_ack, hcnt == 2);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick_1hz = 1;
    @(negedge clk) tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) slow_en = 1;
    @(negedge clk) slow_en = 0;
  endtask

  task automatic wr(int sel, int val);
    @(negedge clk) begin wr_en = 1; wr_sel = 3'(sel); wr_data = tobcd(val); end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic hold_on();
    @(negedge clk) hold_req = 1;
    strobe();
    chk("R8 ack low after one strobe", {7'd0, hold_ack}, 8'd0);
    strobe();
    chk("R8 ack high after two strobes", {7'd0, hold_ack}, 8'd1);
  endtask

  task automatic hold_off();
    @(negedge clk) hold_req = 0;
    @(negedge clk);
    chk("R8 ack falls after release", {7'd0, hold_ack}, 8'd0);
  endtask

  task automatic set_time(int yr, int mo, int dy, int wd, int hr, int mi, int se);
    hold_on();
    wr(0, se); wr(1, mi); wr(2, hr); wr(3, wd); wr(4, dy); wr(5, mo); wr(6, yr);
    hold_off();
    @(negedge clk);
  endtask

  task automatic expect_time(string tag, int yr, int mo, int dy, int wd, int hr, int mi, int se);
    chk({tag, " sec"},  rd_sec,  tobcd(se));
    chk({tag, " min"},  rd_min,  tobcd(mi));
    chk({tag, " hour"}, rd_hour, tobcd(hr));
    chk({tag, " wday"}, rd_wday, tobcd(wd));
    chk({tag, " day"},  rd_day,  tobcd(dy));
    chk({tag, " mon"},  rd_mon,  tobcd(mo));
    chk({tag, " year"}, rd_year, tobcd(yr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_time("R1 reset", 0, 1, 1, 0, 0, 0, 0);
    chk("R1 reset ack", {7'd0, hold_ack}, 8'd0);

    run_en = 1;
    for (int i = 0; i < 10; i++) tick();
    chk("R2 seconds 09 to 10", rd_sec, 8'h10);

    run_en = 0;
    for (int i = 0; i < 3; i++) tick();
    chk("R3 ticks ignored when disabled", rd_sec, 8'h10);
    run_en = 1;

    // R9: write without hold, and with hold but before acknowledge
    wr(0, 45);
    @(negedge clk);
    chk("R9 write ignored without hold", rd_sec, 8'h10);
    @(negedge clk) hold_req = 1;
    wr(1, 33);
    @(negedge clk);
    chk("R9 write ignored before ack", rd_min, 8'h00);
    tick();
    chk("R8 tick ignored during hold", rd_sec, 8'h10);
    hold_off();

    // R9: loaded values appear; select 7 ignored
    set_time(23, 5, 14, 3, 23, 59, 59);
    expect_time("R9 loaded", 23, 5, 14, 3, 23, 59, 59);
    hold_on(); wr(7, 11); hold_off(); @(negedge clk);
    expect_time("R9 select 7 ignored", 23, 5, 14, 3, 23, 59, 59);

    // R10: copy lags live by one cycle
    @(negedge clk) tick_1hz = 1;
    @(negedge clk) tick_1hz = 0;
    chk("R10 copy still old one cycle after tick", rd_sec, 8'h59);
    @(negedge clk);
    expect_time("R4 midnight carry", 23, 5, 15, 4, 0, 0, 0);

    set_time(23, 5, 20, 6, 23, 59, 59); tick();
    expect_time("R5 weekday wrap", 23, 5, 21, 0, 0, 0, 0);
    set_time(23, 4, 30, 1, 23, 59, 59); tick();
    expect_time("R6 thirty day month", 23, 5, 1, 2, 0, 0, 0);
    set_time(23, 1, 31, 1, 23, 59, 59); tick();
    expect_time("R6 long month", 23, 2, 1, 2, 0, 0, 0);
    set_time(99, 12, 31, 5, 23, 59, 59); tick();
    expect_time("R6 year wrap", 0, 1, 1, 6, 0, 0, 0);
    set_time(24, 2, 28, 3, 23, 59, 59); tick();
    expect_time("R7 leap 28 to 29", 24, 2, 29, 4, 0, 0, 0);
    set_time(24, 2, 29, 4, 23, 59, 59); tick();
    expect_time("R7 leap 29 to march", 24, 3, 1, 5, 0, 0, 0);
    set_time(23, 2, 28, 2, 23, 59, 59); tick();
    expect_time("R7 common year", 23, 3, 1, 3, 0, 0, 0);
    set_time(0, 2, 28, 1, 23, 59, 59); tick();
    expect_time("R7 year 00 leap", 0, 2, 29, 2, 0, 0, 0);
    set_time(2, 2, 28, 4, 23, 59, 59); tick();
    expect_time("R7 year 02 common", 2, 3, 1, 5, 0, 0, 0);

    // R4: minute and hour carries over a long run
    set_time(23, 7, 4, 2, 10, 58, 0);
    for (int i = 0; i < 130; i++) tick();
    expect_time("R4 minute and hour carry", 23, 7, 4, 2, 11, 0, 10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule